// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every clock cycle, which hardware thread the instruction fetch stage serves. Each thread reports a 3-bit state code and an active bit. The block turns these into an eligibility mask and applies one of three policies to it: a fixed single-thread choice, a round-robin choice kept as an ordered list, or a choice by smallest queue occupancy.

The fetch stage may serve several threads in one cycle. The block therefore produces `FETCH_SLOTS` grants per cycle, one after another. Each grant after the first sees the list as the earlier grants in the same cycle left it. Once a grant comes out empty, every later grant in that cycle is empty too. A pending drain suppresses every grant.

In round-robin mode the block keeps a priority list of thread IDs. The first eligible entry, scanning from the head, wins. The winner is then taken out of its position and put at the tail, and the entries behind it move one place forward.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is eligible only when its active bit is set and its state code is 0 (running), 1 (idle) or 2 (access complete). Codes 3 to 7 make the thread ineligible. Thread t's code sits in `thr_state[3t+2:3t]`.
- R2: A thread whose `thr_active` bit is clear is never granted in round-robin or count mode, whatever its state code.
- R3: Round-robin mode is policy code 1. The list is scanned from the head, and the first eligible thread is granted. That thread moves to the tail, and the entries that were behind it each move one place toward the head.
- R4: If no thread is eligible under round-robin or count mode, the grant is invalid and the round-robin list is left unchanged.
- R5: Single mode is policy code 0. With more than one thread configured, every slot grants thread 0 as valid, whatever the eligibility. With one thread configured, the grant is valid only when that thread is eligible.
- R6: Count mode is policy codes 2 and 3. The eligible thread with the smallest occupancy wins, and a tie goes to the lower thread ID. Thread t's occupancy sits in `occ_count[OCC_W*(t+1)-1:OCC_W*t]`.
- R7: After reset the list holds the thread IDs in ascending order, with thread 0 at the head.
- R8: Slot k (k ≥ 1) is evaluated on the list as slots 0..k-1 left it in the same cycle. Once a slot is invalid, all higher slots are invalid in that cycle.
- R9: While `drain_pend` is high, every slot is invalid and the list does not change.
- R10: The list changes only in a cycle where the policy is round-robin and slot 0 is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_state | input | 3*NUM_THR | Per-thread state code |
| thr_active | input | NUM_THR | Per-thread active bit |
| policy | input | 2 | 0 single, 1 round-robin, 2/3 occupancy count |
| drain_pend | input | 1 | Suppresses all grants |
| occ_count | input | OCC_W*NUM_THR | Per-thread queue occupancy |
| grant_vld | output | FETCH_SLOTS | Per-slot grant valid |
| grant_tid | output | TID_W*FETCH_SLOTS | Per-slot granted thread ID |

## Verification
Two functions share a cycle: the tail move made by slot 0 and the list scan made by slot 1. Slot 1 must see the list as slot 0 just left it. The bench provokes this by keeping several threads eligible for many cycles at once, in fixed and randomised patterns. It then judges every slot against a queue model that deletes each winner and pushes it to the back before evaluating the next slot. Drain and mode changes land in the middle of these runs, which shows whether the list is held in the cycles where it should be.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_IDLE      = 3'd1,
    ST_ACC_DONE  = 3'd2,
    ST_BLOCKED   = 3'd3,
    ST_SQUASH    = 3'd4,
    ST_WAIT_RESP = 3'd5,
    ST_WAIT_RTRY = 3'd6,
    ST_PARKED    = 3'd7
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_SINGLE = 2'd0,
    POL_RR     = 2'd1,
    POL_COUNT  = 2'd2,
    POL_COUNT2 = 2'd3
  } fetch_pol_e;

  function automatic logic state_fetchable(input logic [2:0] code);
    return (code == ST_RUN) || (code == ST_IDLE) || (code == ST_ACC_DONE);
  endfunction

endpackage

// File: rtl/fts_elig.sv
module fts_elig #(
  parameter int NUM_THR = 4
) (
  input  logic [3*NUM_THR-1:0] thr_state,
  input  logic [NUM_THR-1:0]   thr_active,
  output logic [NUM_THR-1:0]   elig
);
  import fts_pkg::*;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign elig[t] = thr_active[t] & state_fetchable(thr_state[3*t +: 3]);
  end

endmodule

// File: rtl/fts_rr_pick.sv
module fts_rr_pick #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = 2
) (
  input  logic [NUM_THR*TID_W-1:0] order_i,
  input  logic [NUM_THR-1:0]       elig,
  output logic                     hit,
  output logic [TID_W-1:0]         win_tid,
  output logic [NUM_THR*TID_W-1:0] order_o
);
  logic [NUM_THR-1:0][TID_W-1:0] ord_in;
  logic [NUM_THR-1:0][TID_W-1:0] ord_out;

  assign ord_in  = order_i;
  assign order_o = ord_out;

  always_comb begin
    int pos;
    hit     = 1'b0;
    pos     = 0;
    win_tid = '0;
    for (int p = 0; p < NUM_THR; p++) begin
      if (!hit && elig[ord_in[p]]) begin
        hit     = 1'b1;
        pos     = p;
        win_tid = ord_in[p];
      end
    end
    for (int i = 0; i < NUM_THR; i++) begin
      if (!hit || i < pos) begin
        ord_out[i] = ord_in[i];
      end else if (i == NUM_THR - 1) begin
        ord_out[i] = ord_in[pos];
      end else begin
        ord_out[i] = ord_in[(i + 1) % NUM_THR];
      end
    end
  end

endmodule

// File: rtl/fts_min_pick.sv
module fts_min_pick #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = 2,
  parameter int OCC_W   = 5
) (
  input  logic [NUM_THR*OCC_W-1:0] occ_count,
  input  logic [NUM_THR-1:0]       elig,
  output logic                     hit,
  output logic [TID_W-1:0]         win_tid
);
  always_comb begin
    logic [OCC_W-1:0] best;
    hit     = 1'b0;
    best    = '0;
    win_tid = '0;
    for (int i = 0; i < NUM_THR; i++) begin
      if (elig[i] && (!hit || occ_count[OCC_W*i +: OCC_W] < best)) begin
        hit     = 1'b1;
        best    = occ_count[OCC_W*i +: OCC_W];
        win_tid = TID_W'(i);
      end
    end
  end

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int NUM_THR     = 4,
  parameter int FETCH_SLOTS = 2,
  parameter int OCC_W       = 5,
  localparam int TID_W      = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [3*NUM_THR-1:0]         thr_state,
  input  logic [NUM_THR-1:0]           thr_active,
  input  logic [1:0]                   policy,
  input  logic                         drain_pend,
  input  logic [OCC_W*NUM_THR-1:0]     occ_count,
  output logic [FETCH_SLOTS-1:0]       grant_vld,
  output logic [TID_W*FETCH_SLOTS-1:0] grant_tid
);
  import fts_pkg::*;

  logic [NUM_THR-1:0]              elig;
  logic                            cnt_hit;
  logic [TID_W-1:0]                cnt_tid;
  logic                            one_vld;
  logic [TID_W-1:0]                one_tid;
  logic [NUM_THR*TID_W-1:0]        chain [FETCH_SLOTS+1];
  logic [FETCH_SLOTS:0]            alive;
  logic [NUM_THR-1:0][TID_W-1:0]   order_q;
  logic [NUM_THR*TID_W-1:0]        order_nxt;
  logic                            order_en;
  logic                            is_rr;

  assign is_rr = (policy == POL_RR);

  fts_elig #(.NUM_THR(NUM_THR)) u_elig (
    .thr_state  (thr_state),
    .thr_active (thr_active),
    .elig       (elig)
  );

  fts_min_pick #(.NUM_THR(NUM_THR), .TID_W(TID_W), .OCC_W(OCC_W)) u_min (
    .occ_count (occ_count),
    .elig      (elig),
    .hit       (cnt_hit),
    .win_tid   (cnt_tid)
  );

  if (NUM_THR > 1) begin : g_single_multi
    assign one_vld = 1'b1;
    assign one_tid = '0;
  end else begin : g_single_only
    assign one_vld = elig[0];
    assign one_tid = '0;
  end

  assign chain[0] = order_q;
  assign alive[0] = ~drain_pend;

  for (genvar r = 0; r < FETCH_SLOTS; r++) begin : g_slot
    logic                     rr_hit;
    logic [TID_W-1:0]         rr_tid;
    logic [NUM_THR*TID_W-1:0] rr_ord;
    logic                     pick_v;
    logic [TID_W-1:0]         pick_t;

    fts_rr_pick #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_rr (
      .order_i (chain[r]),
      .elig    (elig),
      .hit     (rr_hit),
      .win_tid (rr_tid),
      .order_o (rr_ord)
    );

    always_comb begin
      unique case (policy)
        POL_SINGLE: begin pick_v = one_vld; pick_t = one_tid; end
        POL_RR:     begin pick_v = rr_hit;  pick_t = rr_tid;  end
        default:    begin pick_v = cnt_hit; pick_t = cnt_tid; end
      endcase
    end

    assign grant_vld[r]                 = alive[r] & pick_v;
    assign grant_tid[TID_W*r +: TID_W]  = grant_vld[r] ? pick_t : '0;
    assign alive[r+1]                   = grant_vld[r];
    assign chain[r+1]                   = (is_rr && grant_vld[r]) ? rr_ord : chain[r];
  end

  assign order_nxt = chain[FETCH_SLOTS];
  assign order_en  = is_rr & grant_vld[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_THR; i++) order_q[i] <= TID_W'(i);
    end else if (order_en) begin
      order_q <= order_nxt;
    end
  end

endmodule

// File: rtl/fts_check.sv
module fts_check #(
  parameter int NUM_THR     = 4,
  parameter int FETCH_SLOTS = 2,
  parameter int OCC_W       = 5,
  parameter int TID_W       = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [3*NUM_THR-1:0]         thr_state,
  input logic [NUM_THR-1:0]           thr_active,
  input logic [1:0]                   policy,
  input logic                         drain_pend,
  input logic [OCC_W*NUM_THR-1:0]     occ_count,
  input logic [FETCH_SLOTS-1:0]       grant_vld,
  input logic [TID_W*FETCH_SLOTS-1:0] grant_tid
);
  logic [TID_W-1:0] tid0;
  logic             tid0_ok;
  logic             smaller_exists;

  assign tid0 = grant_tid[TID_W-1:0];

  always_comb begin
    tid0_ok        = 1'b0;
    smaller_exists = 1'b0;
    for (int t = 0; t < NUM_THR; t++) begin
      if (TID_W'(t) == tid0)
        tid0_ok = thr_active[t] && (thr_state[3*t +: 3] <= 3'd2);
    end
    for (int t = 0; t < NUM_THR; t++) begin
      if (thr_active[t] && thr_state[3*t +: 3] <= 3'd2 && TID_W'(t) != tid0) begin
        for (int u = 0; u < NUM_THR; u++) begin
          if (TID_W'(u) == tid0 &&
              (occ_count[OCC_W*t +: OCC_W] < occ_count[OCC_W*u +: OCC_W] ||
               (occ_count[OCC_W*t +: OCC_W] == occ_count[OCC_W*u +: OCC_W] && t < u)))
            smaller_exists = 1'b1;
        end
      end
    end
  end

  a_r9_drain_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    drain_pend |-> (grant_vld == '0));

  a_r5_single_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'd0 && !drain_pend && NUM_THR > 1) |-> (grant_vld[0] && tid0 == '0));

  a_r1_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld[0] && policy != 2'd0) |-> tid0_ok);

  a_r6_count_minimal: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld[0] && policy[1]) |-> !smaller_exists);

  for (genvar r = 1; r < FETCH_SLOTS; r++) begin : g_chk
    a_r8_stop_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_vld[r-1] |-> !grant_vld[r]);
  end

endmodule

bind fetch_thread_sel fts_check #(
  .NUM_THR(NUM_THR), .FETCH_SLOTS(FETCH_SLOTS), .OCC_W(OCC_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_state(thr_state), .thr_active(thr_active),
  .policy(policy), .drain_pend(drain_pend), .occ_count(occ_count),
  .grant_vld(grant_vld), .grant_tid(grant_tid)
);

// File: tb/fetch_thread_sel_test.sv
module fetch_thread_sel_test;
  localparam int NT = 4;
  localparam int NS = 2;
  localparam int OW = 5;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3*NT-1:0]  st;
  logic [NT-1:0]    act;
  logic [1:0]       pol;
  logic             drn;
  logic [OW*NT-1:0] occ;
  logic [NS-1:0]    gv;
  logic [TW*NS-1:0] gt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int ord[$];

  always #2 clk = ~clk;

  fetch_thread_sel #(.NUM_THR(NT), .FETCH_SLOTS(NS), .OCC_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .thr_state(st), .thr_active(act), .policy(pol),
    .drain_pend(drn), .occ_count(occ), .grant_vld(gv), .grant_tid(gt)
  );

  function automatic bit elig_m(int t);
    return act[t] && (st[3*t +: 3] <= 3'd2);
  endfunction

  task automatic set_st(int t, int code);
    st[3*t +: 3] = 3'(code);
  endtask

  task automatic set_occ(int t, int v);
    occ[OW*t +: OW] = OW'(v);
  endtask

  // compare all slots against the queue model, then advance the model
  task automatic step(string tag);
    int q[$];
    bit alive;
    bit ev;
    int et;
    #1;
    q = ord;
    alive = !drn;
    for (int r = 0; r < NS; r++) begin
      ev = 0; et = 0;
      if (alive) begin
        if (pol == 2'd0) begin
          ev = 1; et = 0;
        end else if (pol == 2'd1) begin
          for (int p = 0; p < q.size(); p++) begin
            if (!ev && elig_m(q[p])) begin
              ev = 1; et = q[p];
              q.delete(p);
              q.push_back(et);
            end
          end
        end else begin
          int best = 0;
          for (int t = 0; t < NT; t++) begin
            if (elig_m(t) && (!ev || int'(occ[OW*t +: OW]) < best)) begin
              ev = 1; et = t; best = int'(occ[OW*t +: OW]);
            end
          end
        end
      end
      alive = ev;
      total++;
      if (gv[r] !== ev || (ev && int'(gt[TW*r +: TW]) != et)) begin
        bad++;
        $display("FAIL %s slot %0d: got vld=%0b tid=%0d, expected vld=%0b tid=%0d",
                 tag, r, gv[r], gt[TW*r +: TW], ev, et);
      end
    end
    ord = q;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    st = '0; act = '1; pol = 2'd1; drn = 1'b0; occ = '0;
    ord = {0, 1, 2, 3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7: ascending list after reset, so slots grant 0 then 1
    step("R7");
    // R3 / R8: slot 1 sees the list after slot 0's tail move
    step("R3");
    step("R8");
    // R1: blocked and waiting codes make threads ineligible
    set_st(0, 3); set_st(1, 5);
    step("R1");
    step("R1");
    set_st(0, 1); set_st(1, 2); set_st(2, 4); set_st(3, 6);
    step("R1");
    // R3: a single eligible thread wins every slot
    set_st(0, 7); set_st(1, 0); set_st(2, 7); set_st(3, 7);
    step("R3");
    // R4: nothing eligible -> invalid, list kept
    set_st(1, 3);
    step("R4");
    st = '0;
    step("R4");
    // R2: inactive threads are skipped even when running
    act = 4'b1010;
    step("R2");
    step("R2");
    act = '0;
    step("R2");
    act = '1;
    // R9: drain suppresses all grants and freezes the list
    drn = 1'b1;
    step("R9");
    step("R9");
    drn = 1'b0;
    step("R9");
    // R5: single mode returns thread 0 even when it is ineligible
    pol = 2'd0;
    set_st(0, 5);
    step("R5");
    act = 4'b0000;
    step("R5");
    act = '1; st = '0;
    // R6: count mode, lowest occupancy, ties to the lower ID
    pol = 2'd2;
    set_occ(0, 9); set_occ(1, 4); set_occ(2, 7); set_occ(3, 4);
    step("R6");
    set_st(1, 3);
    step("R6");
    set_occ(0, 2); set_occ(3, 2);
    step("R6");
    pol = 2'd3;
    step("R6");
    // R10: after count mode, round-robin resumes where it was left
    pol = 2'd1; st = '0;
    step("R10");
    step("R10");

    // randomised mix of all functions
    for (int k = 0; k < 600; k++) begin
      st  = 12'($urandom);
      for (int t = 0; t < NT; t++) if ($urandom_range(0, 2) != 0) set_st(t, $urandom_range(0, 2));
      act = 4'($urandom) | 4'($urandom);
      pol = ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'd1;
      drn = ($urandom_range(0, 9) == 0);
      occ = 20'($urandom);
      step("R8");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule